// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is an SPI master that drives a single serial NOR flash device. It accepts one request at a time from a host and turns it into complete command frames on the serial pins. The supported requests are read, page program, 4 KB, 32 KB and 64 KB erase, whole-device erase, and a bare write-enable. Write data and read data move through byte-wide valid/ready streams. Each program or erase is sent as its own write-enable frame, then the command frame, then status-read frames that repeat until the device reports it is idle. Only after that does the controller accept the next request.

Addresses can be given as absolute 24-bit values or relative to a file slot. Slot mode sets aside the first 4 KB block for an index table. The rest of the 4 MiB space is divided into `NUM_SLOTS` equal slots, each a whole number of 4 KB blocks. The serial clock is the system clock divided by `2*CLK_DIV`, and the serial interface uses SPI mode 0.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: SPI mode 0 applies. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low. `miso` is sampled on the rising edge, with 8 bits per byte, MSB first.
- R2: A read (`req_op`=0) is one frame. It carries 0x03, then three address bytes (high first), then `req_len` dummy bytes of 0x00. Each received byte goes out on `rd_data` in order. `rd_valid` and `rd_data` hold until `rd_ready` is seen.
- R3: The address sent is the effective address modulo 4 MiB, so bits 23:22 are zero. A read that runs past 0x3FFFFF continues with the bytes at 0x000000.
- R4: Every program or erase (`req_op` 1 to 5) is preceded by a separate one-byte frame carrying 0x06.
- R5: Erase opcodes are 0x20, 0x52 and 0xD8 for `req_op` 2, 3 and 4. The address low bits are cleared to the region size: bits 11:0, 14:0 and 15:0 respectively.
- R6: Whole-device erase (`req_op`=5) sends a one-byte frame of 0xC7 with no address.
- R7: Page program (`req_op`=1) sends 0x02, three address bytes, then `req_len` bytes taken from the write stream in order. `req_len` is at most 256.
- R8: After a program or erase, the controller sends two-byte frames (0x05, 0x00). It repeats them while bit 0 of the returned status byte is 1 and stops after the first frame that returns bit 0 clear.
- R9: `cs_n` stays high for at least `2*CLK_DIV` system cycles between any two frames.
- R10: `req_ready` is high only when no frame is active or pending. It drops in the cycle after a request is accepted and returns only after the last frame of that request.
- R11: When `req_slot_en` is 1, the effective address is 4096 + `req_slot`·S + `req_addr`. S is the largest multiple of 4096 not above (4 MiB − 4096)/`NUM_SLOTS`.
- R12: `req_op`=6 sends only a one-byte 0x06 frame, with no status polling.
- R13: After reset, `cs_n`=1, `sclk`=0, `req_ready`=1, `rd_valid`=0 and `wr_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_op | input | 3 | Operation code (0 read, 1 program, 2/3/4 erase 4K/32K/64K, 5 device erase, 6 write-enable) |
| req_addr | input | 24 | Byte address or offset within a slot |
| req_len | input | LEN_W | Data byte count for read or program |
| req_slot_en | input | 1 | Add the slot base to the address |
| req_slot | input | SLOT_W | File slot index |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data offered |
| wr_ready | output | 1 | Program byte consumed at this edge when valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The assertions assume the host holds `req_valid` and the request fields steady until acceptance. They also assume the device changes `miso` only while `sclk` is low. The bench's device model drives `miso` only on falling `sclk`. Its host tasks change inputs only at the falling system clock edge and release `req_valid` right after the accepting edge. Program lengths stay within 256, and slot indices stay below `NUM_SLOTS`.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;
  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_PROG = 3'd1, OP_ER4K = 3'd2, OP_ER32K = 3'd3,
    OP_ER64K = 3'd4, OP_CHIP = 3'd5, OP_WREN = 3'd6, OP_RSVD = 3'd7
  } flc_op_e;

  typedef enum logic [1:0] {T_EN, T_MAIN, T_POLL} flc_txn_e;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_RDOUT, S_STEP, S_GAP} flc_st_e;

  function automatic logic [7:0] main_opcode(flc_op_e op);
    case (op)
      OP_READ:  return 8'h03;
      OP_PROG:  return 8'h02;
      OP_ER4K:  return 8'h20;
      OP_ER32K: return 8'h52;
      OP_ER64K: return 8'hD8;
      OP_CHIP:  return 8'hC7;
      default:  return 8'h06;
    endcase
  endfunction

  function automatic logic needs_enable(flc_op_e op);
    return op inside {OP_PROG, OP_ER4K, OP_ER32K, OP_ER64K, OP_CHIP};
  endfunction

  function automatic logic has_addr(flc_op_e op);
    return op inside {OP_READ, OP_PROG, OP_ER4K, OP_ER32K, OP_ER64K};
  endfunction

  // erase size decides how many low address bits are cleared
  function automatic logic [23:0] erase_align(flc_op_e op, logic [23:0] a);
    case (op)
      OP_ER4K:  return {a[23:12], 12'h000};
      OP_ER32K: return {a[23:15], 15'h0000};
      OP_ER64K: return {a[23:16], 16'h0000};
      default:  return a;
    endcase
  endfunction

  function automatic logic [7:0] hdr_byte(logic [1:0] sel, logic [7:0] opc, logic [23:0] a);
    case (sel)
      2'd0:    return opc;
      2'd1:    return a[23:16];
      2'd2:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction
endpackage

// File: rtl/flc_slot_map.sv
`timescale 1ns/1ps
module flc_slot_map #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic [SLOT_W-1:0] slot,
  output logic [23:0]       base
);
  localparam int TOTAL_BLOCKS  = 1024;  // 4 MiB in 4 KB blocks
  localparam int BLK_PER_SLOT  = (TOTAL_BLOCKS - 1) / NUM_SLOTS;
  localparam logic [23:0] SLOT_BYTES = 24'(BLK_PER_SLOT * 4096);

  assign base = 24'd4096 + 24'(slot) * SLOT_BYTES;
endmodule

// File: rtl/flc_byte_shifter.sv
`timescale 1ns/1ps
module flc_byte_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          busy;
  logic [7:0]    sh;
  logic [DW-1:0] div;
  logic [2:0]    nbit;
  logic          half_tick;

  assign half_tick = busy && (div == DW'(CLK_DIV - 1));
  assign mosi      = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; sh <= '0; rx <= '0;
      div  <= '0;   nbit <= '0;   done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; sh <= tx; div <= '0; nbit <= '0;
      end else if (busy) begin
        if (half_tick) begin
          div <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            sh   <= {sh[6:0], 1'b0};
            nbit <= nbit + 3'd1;
            if (nbit == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int NUM_SLOTS = 8,
  parameter int LEN_W     = 9,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [23:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_slot_en,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int IW      = LEN_W + 1;
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  flc_st_e          st;
  flc_txn_e         txn;
  flc_op_e          op_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [IW-1:0]    idx;
  logic [GW-1:0]    gcnt;
  logic             fin;

  // named internal events for the checker
  logic             ev_op_start;
  logic [7:0]       ev_opcode;

  logic [23:0]   slot_base, eff_addr;
  logic [7:0]    cur_opcode, tx_byte, rx_byte;
  logic [IW-1:0] hdr_n, data_n, total_n;
  logic          in_hdr, prog_byte, read_byte, sh_start, sh_done, last_byte;

  flc_slot_map #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .slot(req_slot), .base(slot_base)
  );

  flc_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .done(sh_done), .rx(rx_byte)
  );

  assign eff_addr = ((req_slot_en ? slot_base : 24'd0) + req_addr) & 24'h3F_FFFF;

  always_comb begin
    case (txn)
      T_EN:    cur_opcode = 8'h06;
      T_POLL:  cur_opcode = 8'h05;
      default: cur_opcode = main_opcode(op_q);
    endcase
    hdr_n  = (txn == T_MAIN && has_addr(op_q)) ? IW'(4) : IW'(1);
    data_n = '0;
    if (txn == T_POLL) data_n = IW'(1);
    else if (txn == T_MAIN && (op_q == OP_READ || op_q == OP_PROG)) data_n = IW'(len_q);
    total_n   = hdr_n + data_n;
    in_hdr    = idx < hdr_n;
    prog_byte = (txn == T_MAIN) && (op_q == OP_PROG) && !in_hdr;
    read_byte = (txn == T_MAIN) && (op_q == OP_READ) && !in_hdr;
    tx_byte   = in_hdr ? hdr_byte(idx[1:0], cur_opcode, addr_q)
                       : (prog_byte ? wr_data : 8'h00);
    last_byte = (idx + IW'(1)) == total_n;
  end

  assign req_ready   = (st == S_IDLE);
  assign wr_ready    = (st == S_LOAD) && prog_byte;
  assign sh_start    = (st == S_LOAD) && (!prog_byte || wr_valid);
  assign ev_op_start = sh_start && (idx == '0);
  assign ev_opcode   = cur_opcode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; txn <= T_MAIN; op_q <= OP_READ; addr_q <= '0; len_q <= '0;
      idx <= '0; gcnt <= '0; fin <= 1'b1; cs_n <= 1'b1;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= flc_op_e'(req_op);
          addr_q <= erase_align(flc_op_e'(req_op), eff_addr);
          len_q  <= req_len;
          idx    <= '0;
          cs_n   <= 1'b0;
          txn    <= needs_enable(flc_op_e'(req_op)) ? T_EN : T_MAIN;
          st     <= S_LOAD;
        end
        S_LOAD: if (sh_start) st <= S_SHIFT;
        S_SHIFT: if (sh_done) begin
          if (read_byte) begin
            rd_valid <= 1'b1;
            rd_data  <= rx_byte;
            st       <= S_RDOUT;
          end else begin
            st <= S_STEP;
          end
        end
        S_RDOUT: if (rd_ready) begin
          rd_valid <= 1'b0;
          st       <= S_STEP;
        end
        S_STEP: if (last_byte) begin
          cs_n <= 1'b1; gcnt <= '0; idx <= '0; st <= S_GAP;
          case (txn)
            T_EN:    begin txn <= T_MAIN; fin <= 1'b0; end
            T_MAIN:  begin txn <= T_POLL; fin <= !needs_enable(op_q); end
            default: fin <= !rx_byte[0];
          endcase
        end else begin
          idx <= idx + IW'(1);
          st  <= S_LOAD;
        end
        S_GAP: if (gcnt == GW'(GAP_CYC - 1)) begin
          if (fin) st <= S_IDLE;
          else begin cs_n <= 1'b0; st <= S_LOAD; end
        end else begin
          gcnt <= gcnt + GW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flc_checker.sv
`timescale 1ns/1ps
module flc_checker #(
  parameter int CLK_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       ev_op_start,
  input logic [7:0] ev_opcode
);
  localparam int GAP = 2 * CLK_DIV;

  logic [15:0] hi_run;
  logic [7:0]  last_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= 16'(GAP);
      last_op <= 8'h00;
    end else begin
      if (!cs_n) hi_run <= '0;
      else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
      if (ev_op_start) last_op <= ev_opcode;
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  assert_enable_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_start && (ev_opcode inside {8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7})
      |-> last_op == 8'h06);
  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_run >= 16'(GAP));
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  assert_accept_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

bind flash_cmd_ctrl flc_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .req_valid(req_valid), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .ev_op_start(ev_op_start),
  .ev_opcode(ev_opcode)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int CLK_DIV = 2;
  localparam int NSLOT   = 8;
  localparam int GAPC    = 2 * CLK_DIV;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_slot_en = 0, wr_valid = 0, rd_ready = 0, miso = 0;
  logic [2:0] req_op = 0;
  logic [23:0] req_addr = 0;
  logic [8:0] req_len = 0;
  logic [2:0] req_slot = 0;
  logic [7:0] wr_data = 0;
  logic req_ready, wr_ready, rd_valid, sclk, cs_n, mosi;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.CLK_DIV(CLK_DIV), .NUM_SLOTS(NSLOT)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .req_slot_en(req_slot_en), .req_slot(req_slot), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] log_b[$];
  int         log_len[$];
  int m_bit = 0, m_byte = 0, busy_left = 0;
  logic [7:0] m_in = 0, m_out = 8'hFF, m_opc = 0;
  logic [23:0] m_addr = 0;
  realtime t_rise = 0;

  function automatic logic [7:0] mdata(input int a);
    logic [23:0] v = 24'(a);
    return v[7:0] ^ v[15:8] ^ {2'b00, v[21:16]} ^ 8'hA5;
  endfunction

  always @(negedge cs_n) if (rst_n) begin
    chk(($realtime - t_rise) >= GAPC * 20.0, "R9", "cs_n high time ns",
        longint'($realtime - t_rise), GAPC * 20);
    m_bit = 0; m_byte = 0; m_out = 8'hFF;
  end

  always @(posedge cs_n) begin
    log_len.push_back(m_byte);
    t_rise = $realtime;
    if (m_opc == 8'h05 && m_byte == 2 && busy_left > 0) busy_left--;
  end

  always @(posedge sclk) if (!cs_n) begin
    m_in = {m_in[6:0], mosi};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      log_b.push_back(m_in);
      if (m_byte == 0) m_opc = m_in;
      if (m_byte >= 1 && m_byte <= 3) m_addr = {m_addr[15:0], m_in};
      m_byte++;
      m_out = 8'hFF;
      if (m_opc == 8'h03 && m_byte >= 4)
        m_out = mdata((int'(m_addr) + m_byte - 4) % 4194304);
      if (m_opc == 8'h05 && m_byte == 1) m_out = {7'd0, busy_left > 0};
    end
  end

  always @(negedge sclk) if (!cs_n) miso = m_out[7 - m_bit];

  // R1 pin-level monitors
  int bad_idle = 0, bad_mosi = 0;
  logic p_sclk = 0, p_mosi = 0;
  always @(negedge clk) begin
    if (cs_n && sclk) bad_idle++;
    if (sclk && p_sclk && mosi != p_mosi) bad_mosi++;
    p_sclk = sclk; p_mosi = mosi;
  end

  // ---------------- expected values ----------------
  function automatic int eff_addr(input int a, input bit sen, input int s);
    int slot_bytes = (((4194304 - 4096) / NSLOT) / 4096) * 4096;
    int base = sen ? 4096 + s * slot_bytes : 0;
    return (base + a) % 4194304;
  endfunction

  function automatic int align(input int op, input int a);
    case (op)
      2: return a - (a % 4096);
      3: return a - (a % 32768);
      4: return a - (a % 65536);
      default: return a;
    endcase
  endfunction

  function automatic logic [7:0] opc_of(input int op);
    case (op)
      0: return 8'h03; 1: return 8'h02; 2: return 8'h20; 3: return 8'h52;
      4: return 8'hD8; 5: return 8'hC7; default: return 8'h06;
    endcase
  endfunction

  task automatic do_op(input int op, input int addr, input int len, input bit sen,
                       input int slot, input int polls, input string tag);
    logic [7:0] wbuf[$];
    logic [7:0] got[$];
    logic [7:0] eb[$];
    int el[$];
    int ea;
    bit ok;
    bool_dummy: begin end
    ea = align(op, eff_addr(addr, sen, slot));
    for (int i = 0; i < len; i++) wbuf.push_back(8'($urandom));
    busy_left = polls;
    log_b.delete(); log_len.delete();
    @(negedge clk);
    req_op = 3'(op); req_addr = 24'(addr); req_len = 9'(len);
    req_slot_en = sen; req_slot = 3'(slot); req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10", {tag, " ready after accept"}, req_ready, 0);
    fork
      if (op == 1) begin
        for (int i = 0; i < len; i++) begin
          repeat ($urandom % 3) @(negedge clk);
          wr_valid = 1; wr_data = wbuf[i];
          while (!wr_ready) @(negedge clk);
          @(negedge clk);
          wr_valid = 0;
        end
      end
      if (op == 0) begin
        while (got.size() < len) begin
          rd_ready = 1'($urandom % 2);
          if (rd_valid && rd_ready) got.push_back(rd_data);
          @(negedge clk);
        end
        rd_ready = 0;
      end
    join
    while (!req_ready) @(negedge clk);
    // expected frames
    if (op >= 1 && op <= 5) begin eb.push_back(8'h06); el.push_back(1); end
    eb.push_back(opc_of(op));
    if (op <= 4) begin
      eb.push_back(8'(ea >> 16)); eb.push_back(8'(ea >> 8)); eb.push_back(8'(ea));
      if (op == 1) begin
        foreach (wbuf[i]) eb.push_back(wbuf[i]);
        el.push_back(4 + len);
      end else if (op == 0) begin
        for (int i = 0; i < len; i++) eb.push_back(8'h00);
        el.push_back(4 + len);
      end else el.push_back(4);
    end else el.push_back(1);
    if (op >= 1 && op <= 5)
      for (int p = 0; p <= polls; p++) begin
        eb.push_back(8'h05); eb.push_back(8'h00); el.push_back(2);
      end
    ok = (el.size() == log_len.size()) && (eb.size() == log_b.size());
    if (ok) foreach (el[i]) if (el[i] != log_len[i]) ok = 0;
    if (ok) foreach (eb[i]) if (eb[i] != log_b[i]) ok = 0;
    chk(ok, tag, "frame count / bytes", log_b.size(), eb.size());
    if (op == 0) begin
      ok = (got.size() == len);
      for (int i = 0; i < len && ok; i++)
        if (got[i] != mdata((ea + i) % 4194304)) ok = 0;
      chk(ok, tag, "read data stream", got.size() > 0 ? got[0] : 0,
          len > 0 ? mdata(ea) : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F1A));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(cs_n == 1, "R13", "cs_n", cs_n, 1);
    chk(sclk == 0, "R13", "sclk", sclk, 0);
    chk(req_ready == 1, "R13", "req_ready", req_ready, 1);
    chk(rd_valid == 0 && wr_ready == 0, "R13", "rd_valid|wr_ready",
        rd_valid | wr_ready, 0);
    do_op(6, 24'h000123, 0, 0, 0, 0, "R12 lone enable");
    do_op(0, 24'h001000, 5, 0, 0, 0, "R2 read");
    do_op(0, 24'h3FFFFD, 7, 0, 0, 0, "R3 read wrap");
    do_op(0, 24'hC00010, 3, 0, 0, 0, "R3 upper bits dropped");
    do_op(1, 24'h000000, 256, 1, 7, 1, "R7 R11 full page slot7");
    do_op(2, 24'h123ABC, 0, 0, 0, 0, "R5 R4 erase4k");
    do_op(3, 24'h12ABCD, 0, 0, 0, 2, "R5 erase32k");
    do_op(4, 24'h2FFFFF, 0, 0, 0, 0, "R5 erase64k");
    do_op(5, 24'h0ABCDE, 0, 0, 0, 4, "R6 R8 chip erase polls");
    do_op(0, 24'h000010, 4, 1, 3, 0, "R11 slot read");
    for (int n = 0; n < 30; n++) begin
      int op = $urandom % 7;
      int ln = (op == 1) ? 1 + $urandom % 12 : $urandom % 12;
      do_op(op, int'($urandom % 16777216), ln, 1'($urandom % 2),
            $urandom % NSLOT, $urandom % 3, "R8 random");
    end
    chk(bad_idle == 0, "R1", "sclk high while cs_n high", bad_idle, 0);
    chk(bad_mosi == 0, "R1", "mosi moved while sclk high", bad_mosi, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule